// File: doc/BRIEF.md
# Read-Only Status Target on a Two-Wire Serial Bus

This block is an I2C target that only answers reads. A controller addresses it with a 7-bit address. The top five bits of that address are fixed. The bottom two bits come from strap pins, so up to four copies can share one bus. When the address matches and the direction bit asks for a read, the block acknowledges. It then shifts out an 8-bit status word, most significant bit first, for as long as the controller keeps acknowledging.

The status word combines several flags and levels:

- a sticky power-on flag
- a loop-lock flag
- three port input levels
- a 3-bit converter code, which is saturated to its legal range

The power-on flag is set by reset and by a brown-out pulse. It is cleared only when the controller ends a read by not acknowledging a byte.

The bus pins are sampled through a synchroniser. Transfers are decoded from edges of the sampled SCL. SDA is modelled as a drive-low enable: the board supplies the pull-up and the wired-AND.

Top module: `i2c_status_target`

## Requirements
- R1: An address byte of 1,1,0,0,0,S1,S0 (sent MSB first, where S1,S0 equal `addr_sel_i[1:0]`) followed by a direction bit of 1 is acknowledged: SDA is held low through the ninth SCL clock.
- R2: An address with any other value, or with a direction bit of 0, is not acknowledged, and SDA stays released for every following clock until the next START.
- R3: The status byte is sent MSB first. Bit 7 is the power-on flag, bit 6 is `lock_i`, bits 5..3 are `port_lvl_i[2:0]` (1 = HIGH), and bits 2..0 are the converter code.
- R4: The SDA drive only changes while SCL is low.
- R5: When the controller acknowledges a status byte, another byte is sent, holding status values captured afresh at that acknowledge clock.
- R6: When the controller does not acknowledge, SDA is released and stays released until the next START.
- R7: The power-on flag reads 1 after reset and after any `brownout_i` pulse.
- R8: The power-on flag is cleared only by a controller non-acknowledge that ends a read. A controller acknowledge, or a STOP before the acknowledge bit, leaves it set.
- R9: Converter codes 000 to 100 pass through unchanged. Any code above 100 is reported as 100.
- R10: A START or STOP at any point abandons the current transfer. A new transfer started afterwards behaves normally.
- R11: The status byte is latched on the rising SCL edge of the acknowledge clock. Input changes during the byte do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; also acts as power-on event |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line |
| sda_drive_low_o | output | 1 | 1 pulls SDA low, 0 releases it |
| addr_sel_i | input | 2 | Strap value for the two low address bits |
| lock_i | input | 1 | Loop-lock indication |
| port_lvl_i | input | 3 | Port input levels, 1 = HIGH |
| conv_code_i | input | 3 | Converter code |
| brownout_i | input | 1 | Pulse that sets the power-on flag |

## Verification
The assertions assume a bus that follows the protocol:

- the controller changes SDA only while SCL is low, except when it signals START or STOP;
- it never signals START or STOP while the target is driving;
- each SCL phase lasts longer than the synchroniser plus edge-detect latency.

The bus model in the bench holds every SCL phase for ten clocks. It moves its own SDA only in the middle of the low phase, and issues STOP or repeated START only at points where the target has released the line. The strap and status inputs are changed only while the bus is idle, except in the one test that checks capture coherence.

// File: rtl/i2cst_pkg.sv
package i2cst_pkg;
  localparam int STAT_W    = 8;
  localparam int CONV_W    = 3;
  localparam int PORT_W    = 3;
  localparam int SEL_W     = 2;
  localparam int ADDR_W    = 7;
  localparam int FIXED_W   = ADDR_W - SEL_W;
  localparam int BITCNT_W  = $clog2(STAT_W);
  localparam logic [CONV_W-1:0]  CONV_MAX   = 3'd4;
  localparam logic [FIXED_W-1:0] ADDR_FIXED = 5'b11000;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_CHK, ST_ACK, ST_TX, ST_MACK, ST_WAIT
  } tgt_state_e;

  function automatic logic [CONV_W-1:0] conv_sat(input logic [CONV_W-1:0] c);
    return (c > CONV_MAX) ? CONV_MAX : c;
  endfunction

  function automatic logic addr_hit(input logic [ADDR_W-1:0] a,
                                    input logic [SEL_W-1:0] sel);
    return a == {ADDR_FIXED, sel};
  endfunction

  function automatic logic [STAT_W-1:0] pack_status(
      input logic por, input logic lk,
      input logic [PORT_W-1:0] prt, input logic [CONV_W-1:0] cd);
    return {por, lk, prt, conv_sat(cd)};
  endfunction
endpackage

// File: rtl/i2cst_sync.sv
module i2cst_sync #(
  parameter int STAGES = 2,
  parameter int W      = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '1;
    else        chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '1;
      else        chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/i2cst_bus_events.sv
module i2cst_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;

  p_start_stop_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_ev && stop_ev));
endmodule

// File: rtl/i2cst_por_flag.sv
module i2cst_por_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic brownout,
  input  logic nack_ev,
  output logic por_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        por_q <= 1'b1;
    else if (brownout) por_q <= 1'b1;
    else if (nack_ev)  por_q <= 1'b0;
  end

  p_por_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    brownout |=> por_q);
  p_por_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!brownout && !nack_ev) |=> $stable(por_q));
endmodule

// File: rtl/i2cst_target_fsm.sv
module i2cst_target_fsm
  import i2cst_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scl_s,
  input  logic                sda_s,
  input  logic                scl_rise,
  input  logic                scl_fall,
  input  logic                start_ev,
  input  logic                stop_ev,
  input  logic [SEL_W-1:0]    addr_sel,
  input  logic [STAT_W-1:0]   status_byte,
  output logic                drive_low,
  output logic                tx_load,
  output logic                nack_ev
);
  tgt_state_e           state;
  logic [BITCNT_W-1:0]  bit_cnt;
  logic [STAT_W-1:0]    rx_sh;
  logic [STAT_W-1:0]    tx_sh;
  logic                 addr_ok;
  logic                 bus_ev;

  assign bus_ev  = start_ev | stop_ev;
  assign addr_ok = addr_hit(rx_sh[STAT_W-1:1], addr_sel) & rx_sh[0];
  assign tx_load = ~bus_ev & scl_rise &
                   ((state == ST_ACK) | ((state == ST_MACK) & ~sda_s));
  assign nack_ev = ~bus_ev & scl_rise & (state == ST_MACK) & sda_s;
  assign drive_low = (state == ST_ACK) | ((state == ST_TX) & ~tx_sh[STAT_W-1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bit_cnt <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
    end else if (start_ev) begin
      state   <= ST_ADDR;
      bit_cnt <= '0;
    end else if (stop_ev) begin
      state   <= ST_IDLE;
    end else begin
      if (tx_load) tx_sh <= status_byte;
      case (state)
        ST_ADDR: if (scl_rise) begin
          rx_sh   <= {rx_sh[STAT_W-2:0], sda_s};
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == BITCNT_W'(STAT_W-1)) state <= ST_ADDR_CHK;
        end
        ST_ADDR_CHK: if (scl_fall) state <= addr_ok ? ST_ACK : ST_WAIT;
        ST_ACK: if (scl_fall) begin
          state   <= ST_TX;
          bit_cnt <= '0;
        end
        ST_TX: if (scl_fall) begin
          if (bit_cnt == BITCNT_W'(STAT_W-1)) state <= ST_MACK;
          else begin
            tx_sh   <= {tx_sh[STAT_W-2:0], 1'b0};
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        ST_MACK: begin
          if (nack_ev) state <= ST_WAIT;
          else if (scl_fall) begin
            state   <= ST_TX;
            bit_cnt <= '0;
          end
        end
        default: ;
      endcase
    end
  end

  p_ack_on_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ADDR_CHK && scl_fall && addr_ok && !bus_ev) |=> drive_low);
  p_quiet_on_miss_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ADDR_CHK && scl_fall && !addr_ok && !bus_ev) |=> !drive_low);
  p_drive_scl_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(drive_low) |-> !scl_s);
  p_release_on_nack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    nack_ev |=> !drive_low);
  p_conv_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> (tx_sh[CONV_W-1:0] <= CONV_MAX));
  p_byte_coherent_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TX && !scl_fall && !bus_ev) |=> $stable(tx_sh));
endmodule

// File: rtl/i2c_status_target.sv
module i2c_status_target
  import i2cst_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_drive_low_o,
  input  logic [SEL_W-1:0]  addr_sel_i,
  input  logic              lock_i,
  input  logic [PORT_W-1:0] port_lvl_i,
  input  logic [CONV_W-1:0] conv_code_i,
  input  logic              brownout_i
);
  logic scl_s, sda_s;
  logic scl_rise, scl_fall, start_ev, stop_ev;
  logic tx_load, nack_ev, por_q;
  logic [STAT_W-1:0] status_byte;

  i2cst_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q({scl_s, sda_s}));

  i2cst_bus_events u_events (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev));

  i2cst_por_flag u_por (
    .clk(clk), .rst_n(rst_n), .brownout(brownout_i),
    .nack_ev(nack_ev), .por_q(por_q));

  assign status_byte = pack_status(por_q, lock_i, port_lvl_i, conv_code_i);

  i2cst_target_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev),
    .addr_sel(addr_sel_i), .status_byte(status_byte),
    .drive_low(sda_drive_low_o), .tx_load(tx_load), .nack_ev(nack_ev));
endmodule

// File: tb/tb_i2c_status_target.sv
module tb_i2c_status_target;
  localparam int HP = 10;

  typedef struct packed {
    logic [1:0] sel;
    logic [6:0] addr;
    logic       rw;
    logic       lk;
    logic [2:0] prt;
    logic [2:0] cd;
    logic       ack;
    logic [7:0] byte_exp;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    {2'b01, 7'b1100001, 1'b1, 1'b1, 3'b101, 3'b011, 1'b1, 8'hEB},
    {2'b01, 7'b1100001, 1'b1, 1'b0, 3'b010, 3'b100, 1'b1, 8'h14},
    {2'b10, 7'b1100001, 1'b1, 1'b1, 3'b000, 3'b001, 1'b0, 8'h00},
    {2'b11, 7'b1100011, 1'b0, 1'b1, 3'b111, 3'b010, 1'b0, 8'h00},
    {2'b11, 7'b1100011, 1'b1, 1'b1, 3'b111, 3'b111, 1'b1, 8'h7C},
    {2'b00, 7'b1110000, 1'b1, 1'b0, 3'b001, 3'b000, 1'b0, 8'h00},
    {2'b00, 7'b1100000, 1'b1, 1'b0, 3'b001, 3'b110, 1'b1, 8'h0C},
    {2'b10, 7'b1100010, 1'b1, 1'b1, 3'b110, 3'b010, 1'b1, 8'h72}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda_c = 1'b1;
  logic drv;
  logic [1:0] sel = 2'b00;
  logic lk = 1'b0, bo = 1'b0;
  logic [2:0] prt = 3'b000, cd = 3'b000;
  wire sda_line = sda_c & ~drv;

  int checks = 0, fails = 0, r4_viol = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  i2c_status_target dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_drive_low_o(drv), .addr_sel_i(sel), .lock_i(lk),
    .port_lvl_i(prt), .conv_code_i(cd), .brownout_i(bo));

  logic drv_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && drv !== drv_prev && scl) r4_viol++;
    drv_prev <= drv;
  end

  function automatic logic [7:0] exp_status(input logic p, input logic l,
      input logic [2:0] pr, input logic [2:0] c);
    logic [2:0] cs;
    cs = (c >= 3'd4) ? 3'd4 : c;
    return {p, l, pr, cs};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_c = 1'b1; wclk(HP);
    scl = 1'b1;   wclk(HP);
    sda_c = 1'b0; wclk(HP);
    scl = 1'b0;   wclk(HP);
  endtask

  task automatic bus_stop();
    sda_c = 1'b0; wclk(HP);
    scl = 1'b1;   wclk(HP);
    sda_c = 1'b1; wclk(HP);
  endtask

  task automatic send_bit(input logic b);
    sda_c = b; wclk(HP);
    scl = 1'b1; wclk(HP);
    scl = 1'b0;
  endtask

  task automatic read_bit(output logic b);
    sda_c = 1'b1; wclk(HP);
    scl = 1'b1; wclk(HP/2);
    b = sda_line; wclk(HP - HP/2);
    scl = 1'b0;
  endtask

  task automatic send_addr(input logic [6:0] a, input logic rw, output logic acked);
    logic b;
    bus_start();
    for (int i = 6; i >= 0; i--) send_bit(a[i]);
    send_bit(rw);
    read_bit(b);
    acked = ~b;
  endtask

  task automatic read_byte(input int flip_at, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      if (7 - i == flip_at) begin
        lk = ~lk; prt = ~prt; cd = ~cd;
      end
      read_bit(b);
      v[i] = b;
    end
  endtask

  task automatic released_clocks(input int n, input string req);
    logic b;
    int lows;
    lows = 0;
    for (int i = 0; i < n; i++) begin
      read_bit(b);
      if (!b) lows++;
    end
    check(lows == 0, req, lows, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog (all R) actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] v;
    logic [7:0] e;
    logic [2:0] prt0, cd0;
    logic lk0;
    wclk(5);
    rst_n = 1'b1;
    wclk(5);
    check(drv == 1'b0, "R6 reset releases SDA", drv, 0);

    // Table: R1 R2 R3 R7 R9 (row 0 also clears the power-on flag by NACK, R8)
    for (int r = 0; r < NV; r++) begin
      sel = VEC[r].sel; lk = VEC[r].lk; prt = VEC[r].prt; cd = VEC[r].cd;
      wclk(HP);
      send_addr(VEC[r].addr, VEC[r].rw, ack);
      check(ack == VEC[r].ack, "R1/R2 address ack", ack, VEC[r].ack);
      if (VEC[r].ack) begin
        read_byte(-1, v);
        check(v == VEC[r].byte_exp, "R3/R7/R9 status byte", v, VEC[r].byte_exp);
        send_bit(1'b1);
      end else begin
        released_clocks(9, "R2 SDA released after miss");
      end
      bus_stop();
    end

    // R5 / R7 / R8: brown-out, two-byte read, ACK keeps flag, NACK clears it
    sel = 2'b01; lk = 1'b1; prt = 3'b011; cd = 3'b001;
    bo = 1'b1; wclk(1); bo = 1'b0; wclk(HP);
    send_addr(7'b1100001, 1'b1, ack);
    check(ack, "R1 ack", ack, 1);
    read_byte(-1, v);
    e = exp_status(1'b1, 1'b1, 3'b011, 3'b001);
    check(v == e, "R7 flag after brown-out", v, e);
    lk = 1'b0; prt = 3'b100; cd = 3'b101;
    send_bit(1'b0);
    read_byte(-1, v);
    e = exp_status(1'b1, 1'b0, 3'b100, 3'b101);
    check(v == e, "R5/R8 second byte fresh, flag kept", v, e);
    send_bit(1'b1);
    released_clocks(9, "R6 released after NACK");
    bus_stop();
    send_addr(7'b1100001, 1'b1, ack);
    read_byte(-1, v);
    e = exp_status(1'b0, 1'b0, 3'b100, 3'b101);
    check(v == e, "R8 flag cleared by NACK", v, e);
    send_bit(1'b1);
    bus_stop();

    // R8: STOP before the acknowledge bit keeps the flag
    bo = 1'b1; wclk(1); bo = 1'b0; wclk(HP);
    send_addr(7'b1100001, 1'b1, ack);
    read_byte(-1, v);
    bus_stop();
    send_addr(7'b1100001, 1'b1, ack);
    read_byte(-1, v);
    e = exp_status(1'b1, 1'b0, 3'b100, 3'b101);
    check(v == e, "R8 flag kept after STOP abort", v, e);
    send_bit(1'b1);
    bus_stop();

    // R11: inputs flip during the byte
    lk0 = 1'b1; prt0 = 3'b010; cd0 = 3'b011;
    lk = lk0; prt = prt0; cd = cd0; wclk(HP);
    send_addr(7'b1100001, 1'b1, ack);
    read_byte(3, v);
    e = exp_status(1'b0, lk0, prt0, cd0);
    check(v == e, "R11 byte coherent", v, e);
    send_bit(1'b1);
    bus_stop();

    // R10: repeated START mid-address, then STOP mid-address
    lk = 1'b0; prt = 3'b101; cd = 3'b100; wclk(HP);
    bus_start();
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    send_addr(7'b1100001, 1'b1, ack);
    check(ack, "R10 ack after repeated START", ack, 1);
    read_byte(-1, v);
    e = exp_status(1'b0, 1'b0, 3'b101, 3'b100);
    check(v == e, "R10 byte after repeated START", v, e);
    send_bit(1'b1);
    bus_stop();
    bus_start();
    for (int i = 0; i < 3; i++) send_bit(1'b1);
    bus_stop();
    send_addr(7'b1100001, 1'b1, ack);
    check(ack, "R10 ack after STOP abort", ack, 1);
    read_byte(-1, v);
    check(v == e, "R10 byte after STOP abort", v, e);
    send_bit(1'b1);
    bus_stop();

    wclk(HP);
    check(r4_viol == 0, "R4 drive changes with SCL low", r4_viol, 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule